// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator

This block produces one pulse-width modulated output from three registers loaded through a simple synchronous write port. The registers are a control word, a period limit and a duty threshold. The source clock first passes through an optional fixed divide-by-1625 stage and then through a power-of-two divider. The result is a tick that advances a 13-bit period counter. The output is high while that counter is below the duty threshold.

Software disables the block and programs the period and duty. It then sets the enable bit together with the divider settings. While the block runs, new values are collected in staging registers and copied into the working set only when the counter wraps. A period in progress therefore always finishes with the settings it started with. Chaining the fixed stage ahead of the power-of-two stage gives periods hundreds of thousands of times longer than the counter alone can reach.

Top module: `pwm_prescaled`

## Requirements
- R1: After reset every register reads as zero, the block is disabled and `pwm_out` is low until software enables it.
- R2: A write with `wr_en` high stores `wr_data` in the register chosen by `wr_sel`: 0 control, 1 period, 2 duty. A `wr_sel` of 3 changes nothing. The period and duty registers keep only bits 12:0 of the data.
- R3: In the control word, bit 15 enables the block, bit 3 selects the extra divide-by-1625 stage and bits 2:0 hold the shift n. The tick interval is D = 2^n source cycles, or D = 1625·2^n cycles when bit 3 is set.
- R4: While enabled with period value W, the output repeats every (W+1)·D source cycles.
- R5: With duty value T where 1 ≤ T ≤ W, each output pulse is high for T·D cycles and low for (W+1−T)·D cycles.
- R6: A duty value greater than W holds the output constantly high. A duty value of 0 holds it constantly low.
- R7: Period, duty and control writes made while the block runs take effect only at the next counter wrap. The period in progress completes with its old high and low times.
- R8: Clearing the enable bit drives the output low from the cycle after the write and holds all counters at zero. On re-enable, counting restarts from zero, so the first pulse is a full-length one.
- R9: The period counter never exceeds the active period value while running.
- R10: The fixed-stage counter always stays below 1625.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 period, 2 duty, 3 none |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest situation to reach from the ports is a register write that lands inside a running period. To check it, the new value must be shown not to truncate that period, and then to apply exactly one wrap later. The stimulus watches the output for a rising edge, which marks the counter wrap. It issues new period and duty writes immediately after that edge, then measures the pulse in progress against the old settings and the following pulse against the new ones. The fixed divide-by-1625 path is reached with small period values, so that pulses millions of cycles long are not needed to see its effect.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int PWM_DATA_W  = 16;
    localparam int PWM_CNT_W   = 13;
    localparam int PWM_SHIFT_W = 3;
    localparam int PWM_FIX_DIV = 1625;
    localparam int PWM_EN_BIT  = 15;
    localparam int PWM_FIX_BIT = 3;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_DUTY   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pwm_fixdiv.sv
// Fixed-ratio prescale stage: one-cycle pulse every FIX_DIV cycles when used,
// otherwise a pulse every cycle.
module pwm_fixdiv #(
    parameter int FIX_DIV = pwm_pkg::PWM_FIX_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic use_fix,
    output logic pulse
);
    localparam int FW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;
    localparam logic [FW-1:0] LAST = FW'(FIX_DIV - 1);

    typedef struct packed {
        logic [FW-1:0] cnt;
    } fix_state_t;

    fix_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        pulse = 1'b1;
        if (use_fix) begin
            pulse = (st_q.cnt == LAST);
        end
        if (clear || !use_fix) begin
            st_d.cnt = '0;
        end else if (pulse) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_FIX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST); // R10

    AST_FIX_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && use_fix && !clear && FIX_DIV > 1) |=> (!use_fix || !pulse)); // R3

endmodule

// File: rtl/pwm_pow2div.sv
// Power-of-two stage: advances on each step, ticks when the low SHIFT bits are all ones.
module pwm_pow2div #(
    parameter int SHIFT_W = pwm_pkg::PWM_SHIFT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PW = (2 ** SHIFT_W) - 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } p2_state_t;

    p2_state_t   st_d, st_q;
    logic [PW-1:0] mask;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            mask[i] = (32'(i) < 32'(shift));
        end
    end

    always_comb begin
        st_d = st_q;
        tick = step && ((st_q.cnt & mask) == mask);
        if (clear) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_POW2_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |=> ((st_q.cnt & $past(mask)) == '0)); // R3

    AST_POW2_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(st_q.cnt)); // R3

endmodule

// File: rtl/pwm_period_cnt.sv
// Period counter and output compare.
module pwm_period_cnt #(
    parameter int CNT_W = pwm_pkg::PWM_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] thresh,
    output logic             wrap,
    output logic             level
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pc_state_t;

    pc_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        wrap  = run && tick && (st_q.cnt == limit);
        level = run && (st_q.cnt < thresh);
        if (!run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = (st_q.cnt == limit) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_LE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (st_q.cnt <= limit)); // R9

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0)); // R8

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (!run || $stable(st_q.cnt))); // R4

endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled #(
    parameter int DATA_W  = pwm_pkg::PWM_DATA_W,
    parameter int CNT_W   = pwm_pkg::PWM_CNT_W,
    parameter int SHIFT_W = pwm_pkg::PWM_SHIFT_W,
    parameter int FIX_DIV = pwm_pkg::PWM_FIX_DIV,
    parameter int EN_BIT  = pwm_pkg::PWM_EN_BIT,
    parameter int FIX_BIT = pwm_pkg::PWM_FIX_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out
);
    import pwm_pkg::*;

    typedef struct packed {
        logic               en;
        logic               fix;
        logic [SHIFT_W-1:0] shift;
    } ctrl_t;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] limit;
        logic [CNT_W-1:0] thresh;
    } cfg_t;

    typedef struct packed {
        cfg_t stg;
        cfg_t act;
    } top_state_t;

    top_state_t st_d, st_q;
    logic run, load, fix_pulse, tick, wrap, level;

    assign run  = st_q.stg.ctrl.en && st_q.act.ctrl.en;
    assign load = !run || wrap;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_CTRL: begin
                    st_d.stg.ctrl.en    = wr_data[EN_BIT];
                    st_d.stg.ctrl.fix   = wr_data[FIX_BIT];
                    st_d.stg.ctrl.shift = wr_data[SHIFT_W-1:0];
                end
                SEL_PERIOD: st_d.stg.limit  = wr_data[CNT_W-1:0];
                SEL_DUTY:   st_d.stg.thresh = wr_data[CNT_W-1:0];
                SEL_NONE:   ;
                default:    ;
            endcase
        end
        if (load) begin
            st_d.act = st_q.stg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pwm_fixdiv #(.FIX_DIV(FIX_DIV)) i_fixdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load),
        .use_fix (st_q.act.ctrl.fix),
        .pulse   (fix_pulse)
    );

    pwm_pow2div #(.SHIFT_W(SHIFT_W)) i_pow2div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .step  (fix_pulse && run),
        .shift (st_q.act.ctrl.shift),
        .tick  (tick)
    );

    pwm_period_cnt #(.CNT_W(CNT_W)) i_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (tick),
        .limit  (st_q.act.limit),
        .thresh (st_q.act.thresh),
        .wrap   (wrap),
        .level  (level)
    );

    assign pwm_out = level;

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> $stable(st_q.act)); // R7

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.stg.ctrl.en |-> !pwm_out); // R8

    AST_NONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> $stable(st_q.stg)); // R2

endmodule

// File: tb/test_pwm_prescaled.sv
module test_pwm_prescaled;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 190000;
    localparam int FIX        = 1625;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int rise_cnt = 0;
    int hi_last = 0;
    int lo_last = 0;
    int run_len = 0;
    logic prev_out = 1'b0;

    pwm_prescaled i_pwm_prescaled (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Phase-length monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pwm_out !== prev_out) begin
                if (pwm_out) begin
                    lo_last = run_len;
                    rise_cnt = rise_cnt + 1;
                end else begin
                    hi_last = run_len;
                end
                run_len = 1;
            end else begin
                run_len = run_len + 1;
            end
            prev_out = pwm_out;
        end
    end

    function automatic int tick_len(input bit fix, input int shift);
        return (fix ? FIX : 1) << shift;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks = checks + 1;
        if (got != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic window_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    task automatic setup(input bit fix, input int shift, input int w, input int d,
                         input bit wait_pulse);
        int r0;
        wr(0, 0);
        wr(1, w);
        wr(2, d);
        r0 = rise_cnt;
        wr(0, 16'h8000 | (int'(fix) << 3) | shift);
        if (wait_pulse) wait (rise_cnt >= r0 + 2);
    endtask

    task automatic check_pulse(input string tag, input bit fix, input int shift,
                               input int w, input int d);
        int dl;
        dl = tick_len(fix, shift);
        check({tag, " high"}, hi_last, d * dl);
        check({tag, " low"}, lo_last, (w + 1 - d) * dl);
    endtask

    initial begin
        int hi, r, seed, sh, w, d;
        seed = $urandom(32'h5EED1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset
        window_high(20, hi);
        check("R1 reset output low", hi, 0);

        // R5/R8: first pulse after enable is full length, plain clock
        setup(1'b0, 0, 9, 4, 1'b1);
        check_pulse("R5 R8 first pulse", 1'b0, 0, 9, 4);

        // R4: steady-state pulse, shift 2
        setup(1'b0, 2, 6, 3, 1'b1);
        r = rise_cnt; wait (rise_cnt >= r + 1);
        check_pulse("R4 steady shift2", 1'b0, 2, 6, 3);

        // R5: duty equal to period value, maximum shift
        setup(1'b0, 7, 2, 2, 1'b1);
        check_pulse("R5 duty=W shift7", 1'b0, 7, 2, 2);

        // R3: fixed stage, shift 0 and shift 1
        setup(1'b1, 0, 3, 1, 1'b1);
        check_pulse("R3 fixed shift0", 1'b1, 0, 3, 1);
        setup(1'b1, 1, 1, 1, 1'b1);
        check_pulse("R3 fixed shift1", 1'b1, 1, 1, 1);

        // R4/R5: random settings
        for (int k = 0; k < 6; k++) begin
            sh = $urandom_range(0, 5);
            w  = $urandom_range(2, 20);
            d  = $urandom_range(1, w);
            setup(1'b0, sh, w, d, 1'b1);
            check_pulse("R4 R5 random", 1'b0, sh, w, d);
        end

        // R6: duty above period value -> constant high; zero duty -> constant low
        setup(1'b0, 1, 5, 9, 1'b0);
        repeat (6) @(negedge clk);
        window_high(60, hi);
        check("R6 constant high", hi, 60);
        setup(1'b0, 1, 5, 0, 1'b0);
        window_high(60, hi);
        check("R6 constant low", hi, 0);

        // R2: masked period bits, then select 3 ignored
        setup(1'b0, 0, 9, 4, 1'b1);
        wr(1, 16'hE00C);
        r = rise_cnt; wait (rise_cnt >= r + 2);
        check_pulse("R2 period masked to 12", 1'b0, 0, 12, 4);
        wr(3, 16'h0001);
        r = rise_cnt; wait (rise_cnt >= r + 2);
        check_pulse("R2 select 3 ignored", 1'b0, 0, 12, 4);

        // R7: writes mid-period apply at the next wrap
        setup(1'b0, 1, 15, 5, 1'b1);
        r = rise_cnt; wait (rise_cnt >= r + 1);
        wr(1, 7);
        wr(2, 2);
        wait (rise_cnt >= r + 2);
        check_pulse("R7 old period completes", 1'b0, 1, 15, 5);
        wait (rise_cnt >= r + 3);
        check_pulse("R7 new values after wrap", 1'b0, 1, 7, 2);

        // R8: disable while high forces low on the following cycle
        r = rise_cnt; wait (rise_cnt >= r + 1);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h0000;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 low after disable", int'(pwm_out), 0);
        window_high(50, hi);
        check("R8 stays low", hi, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule